// File: doc/BRIEF.md
# Power-Up Sequencing State Controller

This block is the digital sequencer of a power-management device. It watches an enable pin, a power-hold input from the host processor and one power-good flag per regulator. From these it switches a bank of regulator enables on in a fixed order, releases the host reset and keeps a sticky sequence-done status bit. All delays are counted in ticks of an external timer strobe and are programmed through three configuration inputs.

The first start-up after a power cycle is triggered by the enable pin. Once a start-up has completed, the sequence-done bit hands control to the power-hold input. From then on, enable alone cannot start the rails, and power-hold both starts and stops them. If power-hold is missing at the moment the reset would be released, the block turns the rails off again instead of going active.

The start indication is an open-drain, active-low pin, modelled as an output enable plus a data bit tied low. There is no streaming data path, so every pin is a plain level signal without valid/ready handshake or back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `reg_en` is all zeros, `rst_rel` is 0, `seq_done` is 0, `start_oe` is 0 and `start_dat` is 0.
- R2: In OFF with `seq_done` at 0, a high `en_pin` at a clock edge starts a start-up. The first delay lasts `cfg_first_dly` ticks, and then `reg_en` bit 0 turns on.
- R3: Regulators turn on in rising index order, one more every `cfg_slot_dly` ticks. During turn-off they go off in falling index order at the same pace. `reg_en` never changes by more than one bit per clock.
- R4: `seq_done` becomes 1 only after the last slot has expired with every `pgood` bit high. While any `pgood` bit is low, the block waits with all rails on and `rst_rel` low.
- R5: While `seq_done` is 1 and the block is OFF, a high `en_pin` alone does not start the rails. A high `hold_in` starts a new start-up.
- R6: `seq_done` clears when `en_pin` is low while the block is OFF.
- R7: `seq_done` clears in any state once `en_pin` has stayed low for `cfg_lo_timeout` ticks. A high `en_pin` restarts that count.
- R8: When `cfg_first_dly` is nonzero, `start_oe` is 1 (pin driven low) exactly while `en_pin` is high and the first delay is running. `start_dat` is always 0.
- R9: When `cfg_first_dly` is 0, a start-up opens a window of `PULSE_TICKS` ticks. During that window `start_oe` equals `en_pin`.
- R10: If `hold_in` is low when the last slot completes, the block goes to turn-off and `rst_rel` never rises.
- R11: `rst_rel` is 1 only in the active state, where all rails are on. A low `hold_in` in the active state starts a turn-off, and `rst_rel` stays 0 through turn-off and OFF.
- R12: A `hold_in` that is already high before the start-up begins counts as confirmation, and the block goes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| tick | input | 1 | Timer strobe, one clock wide |
| en_pin | input | 1 | Enable pin level |
| hold_in | input | 1 | Power-hold from host processor |
| pgood | input | NREG | Per-regulator power-good flags |
| cfg_first_dly | input | DW | First start-up delay in ticks |
| cfg_slot_dly | input | DW | Per-regulator slot delay in ticks |
| cfg_lo_timeout | input | DW | Enable-low timeout in ticks |
| reg_en | output | NREG | Regulator enables |
| start_oe | output | 1 | Drive enable of the open-drain start pin |
| start_dat | output | 1 | Data of the start pin, constant 0 |
| rst_rel | output | 1 | Host reset release, high when active |
| seq_done | output | 1 | Sticky sequence-done status |

## Verification
The main function is exercised with four start-up patterns:
- Power-hold already high: this separates confirmation given before start-up from a late one.
- Power-hold low through the end of start-up: this separates the automatic turn-off from a normal entry into active.
- Enable held high after a completed sequence: this shows that the done bit, not the enable level, now decides a restart.
- One power-good flag withheld: this separates "slots expired" from "rails good".

Enable is also toggled inside the first delay, dropped in OFF and dropped for the timeout while active, which tells apart the three ways the done bit can clear. A zero first delay checks the fixed start pulse against the gated, delay-long one.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    S_OFF   = 3'd0,
    S_DELAY = 3'd1,
    S_RAMP  = 3'd2,
    S_ON    = 3'd3,
    S_DOWN  = 3'd4
  } psc_state_e;
endpackage

// File: rtl/psc_down_cnt.sv
module psc_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

  // R3: the count only moves on a load or a tick
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/psc_en_watch.sv
module psc_en_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en_pin,
  input  logic [W-1:0] timeout,
  output logic         expired
);
  logic [W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lo_q <= '0;
    else if (en_pin)                    lo_q <= '0;
    else if (tick && lo_q != timeout)   lo_q <= lo_q + 1'b1;
  end

  assign expired = !en_pin && (lo_q == timeout);

  // R7: a high enable restarts the low-time count
  p_lo_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_pin |=> (lo_q == '0));
endmodule

// File: rtl/psc_rail_bank.sv
module psc_rail_bank #(
  parameter int NREG = 4,
  parameter int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [CW-1:0]   on_cnt,
  output logic [NREG-1:0] reg_en
);
  logic [CW-1:0] on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                on_q <= '0;
    else if (inc && on_q != CW'(NREG))         on_q <= on_q + 1'b1;
    else if (dec && on_q != '0)                on_q <= on_q - 1'b1;
  end

  assign on_cnt = on_q;

  for (genvar i = 0; i < NREG; i++) begin : g_rail
    assign reg_en[i] = (on_q > CW'(i));
  end

  // R3: rails switch one at a time
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_en ^ $past(reg_en)) <= 1);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NREG        = 4,
  parameter int DW          = 8,
  parameter int PULSE_TICKS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en_pin,
  input  logic            hold_in,
  input  logic [NREG-1:0] pgood,
  input  logic [DW-1:0]   cfg_first_dly,
  input  logic [DW-1:0]   cfg_slot_dly,
  input  logic [DW-1:0]   cfg_lo_timeout,
  output logic [NREG-1:0] reg_en,
  output logic            start_oe,
  output logic            start_dat,
  output logic            rst_rel,
  output logic            seq_done
);
  import psc_pkg::*;

  localparam int CW = $clog2(NREG + 1);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  psc_state_e    st_q, st_d;
  logic          ld, setd, inc, dec, pls_ld;
  logic [DW-1:0] ld_val;
  logic          cnt_zero, pls_zero, lo_exp, all_good;
  logic [CW-1:0] on_cnt;
  logic          done_clr;

  assign all_good = &pgood;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = cfg_slot_dly;
    setd   = 1'b0;
    inc    = 1'b0;
    dec    = 1'b0;
    pls_ld = 1'b0;
    unique case (st_q)
      S_OFF: begin
        if ((!seq_done && en_pin) || (seq_done && hold_in)) begin
          st_d   = S_DELAY;
          ld     = 1'b1;
          ld_val = cfg_first_dly;
          pls_ld = (cfg_first_dly == '0);
        end
      end
      S_DELAY: begin
        if (cnt_zero) begin
          st_d = S_RAMP;
          inc  = 1'b1;
          ld   = 1'b1;
        end
      end
      S_RAMP: begin
        if (cnt_zero) begin
          if (on_cnt != CW'(NREG)) begin
            inc = 1'b1;
            ld  = 1'b1;
          end else if (all_good) begin
            setd = 1'b1;
            ld   = 1'b1;
            st_d = hold_in ? S_ON : S_DOWN;
          end
        end
      end
      S_ON: begin
        if (!hold_in) begin
          st_d = S_DOWN;
          ld   = 1'b1;
        end
      end
      S_DOWN: begin
        if (on_cnt == '0) begin
          st_d = S_OFF;
        end else if (cnt_zero) begin
          dec = 1'b1;
          ld  = 1'b1;
        end
      end
      default: st_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_OFF;
    else        st_q <= st_d;
  end

  assign done_clr = (st_q == S_OFF && !en_pin) || lo_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seq_done <= 1'b0;
    else if (setd)     seq_done <= 1'b1;
    else if (done_clr) seq_done <= 1'b0;
  end

  psc_down_cnt #(.W(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(ld), .load_val(ld_val), .cnt_zero(cnt_zero)
  );

  psc_down_cnt #(.W(PW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(pls_ld), .load_val(PW'(PULSE_TICKS)), .cnt_zero(pls_zero)
  );

  psc_en_watch #(.W(DW)) u_watch (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en_pin(en_pin), .timeout(cfg_lo_timeout), .expired(lo_exp)
  );

  psc_rail_bank #(.NREG(NREG), .CW(CW)) u_rails (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
    .on_cnt(on_cnt), .reg_en(reg_en)
  );

  assign start_oe  = en_pin &&
                     (((st_q == S_DELAY) && (cfg_first_dly != '0)) || !pls_zero);
  assign start_dat = 1'b0;
  assign rst_rel   = (st_q == S_ON);

  // R11: reset is released only with every rail on
  p_rel_all_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rel |-> (&reg_en));
  // R4: done rises only after all rails reported good
  p_done_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(all_good));
  // R6: done falls only after a low enable
  p_done_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_done) |-> $past(!en_pin));
  // R5: with done set and no power-hold, OFF is kept
  p_no_en_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_OFF && seq_done && !hold_in) |=> (st_q == S_OFF));
  // R10: a ramp ends in turn-off only without power-hold
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_RAMP && st_q == S_DOWN) |-> $past(!hold_in));
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int PT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic en = 1'b0, hold = 1'b0;
  logic [N-1:0] pg = '1;
  logic [DW-1:0] t1 = 8'd6, slot = 8'd2, tout = 8'd3;
  logic [N-1:0] reg_en;
  logic start_oe, start_dat, rst_rel, seq_done;

  int checks = 0, errs = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.NREG(N), .DW(DW), .PULSE_TICKS(PT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_pin(en), .hold_in(hold),
    .pgood(pg), .cfg_first_dly(t1), .cfg_slot_dly(slot),
    .cfg_lo_timeout(tout), .reg_en(reg_en), .start_oe(start_oe),
    .start_dat(start_dat), .rst_rel(rst_rel), .seq_done(seq_done)
  );

  // tick every other clock
  always @(negedge clk) begin
    cyc++;
    tick = (cyc % 2 == 0);
  end

  // behavioural reference: 0 off, 1 first delay, 2 ramp, 3 active, 4 turn-off
  int m_st, m_cnt, m_on, m_pls, m_lo;
  bit m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_on = 0; m_pls = 0; m_lo = 0; m_done = 0;
    end else begin
      int nst, non, nv;
      bit ld, setd, pl, lo_exp;
      nst = m_st; non = m_on; ld = 0; nv = slot; setd = 0; pl = 0;
      lo_exp = !en && (m_lo == tout);
      if (m_st == 0) begin
        if ((!m_done && en) || (m_done && hold)) begin
          nst = 1; ld = 1; nv = t1; pl = (t1 == 0);
        end
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin nst = 2; non = 1; ld = 1; end
      end else if (m_st == 2) begin
        if (m_cnt == 0) begin
          if (m_on < N) begin non = m_on + 1; ld = 1; end
          else if (pg == '1) begin setd = 1; ld = 1; nst = hold ? 3 : 4; end
        end
      end else if (m_st == 3) begin
        if (!hold) begin nst = 4; ld = 1; end
      end else begin
        if (m_on == 0) nst = 0;
        else if (m_cnt == 0) begin non = m_on - 1; ld = 1; end
      end
      if (setd) m_done = 1;
      else if ((m_st == 0 && !en) || lo_exp) m_done = 0;
      if (ld) m_cnt = nv; else if (tick && m_cnt != 0) m_cnt--;
      if (pl) m_pls = PT; else if (tick && m_pls != 0) m_pls--;
      if (en) m_lo = 0; else if (tick && m_lo != tout) m_lo++;
      m_st = nst; m_on = non;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
    checks++;
    if (act !== exp_v) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [N-1:0] e_en;
      #2;
      for (int i = 0; i < N; i++) e_en[i] = (m_on > i);
      chk(reg_en, e_en, "R3 reg_en vs model");
      chk(start_oe, en && ((m_st == 1 && t1 != 0) || m_pls != 0), "R8/R9 start_oe vs model");
      chk(rst_rel, m_st == 3, "R11 rst_rel vs model");
      chk(seq_done, m_done, "R4 seq_done vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    bit seen_rel;
    step(3);
    rst_n = 1'b1;
    step(1);
    #2;
    // R1 reset state
    chk(reg_en, 0, "R1 reg_en");
    chk(rst_rel, 0, "R1 rst_rel");
    chk(seq_done, 0, "R1 seq_done");
    chk(start_oe, 0, "R1 start_oe");
    chk(start_dat, 0, "R1 start_dat");
    cmp_on = 1'b1;

    // R2 / R8 / R12: hold already high, enable starts
    @(negedge clk); hold = 1; en = 1;
    step(2); #2;
    chk(start_oe, 1, "R8 start driven in first delay");
    chk(reg_en, 0, "R2 no rail during first delay");
    @(negedge clk); en = 0; #2;
    chk(start_oe, 0, "R8 start released when enable low");
    @(negedge clk); en = 1;
    for (int i = 0; i < 300 && !rst_rel; i++) @(negedge clk);
    #2;
    chk(rst_rel, 1, "R12 active with early hold");
    chk(seq_done, 1, "R4 done after ramp");
    chk(reg_en, 3'b111, "R3 all rails on");

    // R11 hold drop turns off
    @(negedge clk); hold = 0;
    for (int i = 0; i < 300 && reg_en != 0; i++) @(negedge clk);
    step(3); #2;
    chk(reg_en, 0, "R11 rails off after hold drop");
    chk(rst_rel, 0, "R11 reset held in OFF");

    // R5 enable alone does not restart
    step(30); #2;
    chk(reg_en, 0, "R5 no restart on enable alone");
    chk(seq_done, 1, "R5 done kept while enable high");
    @(negedge clk); hold = 1;
    for (int i = 0; i < 300 && !rst_rel; i++) @(negedge clk);
    #2;
    chk(rst_rel, 1, "R5 hold restarts");

    // R6 enable low in OFF clears done
    @(negedge clk); hold = 0;
    for (int i = 0; i < 300 && reg_en != 0; i++) @(negedge clk);
    step(3);
    @(negedge clk); en = 0;
    step(2); #2;
    chk(seq_done, 0, "R6 cleared by low enable in OFF");

    // R10 missing hold at end of start-up
    @(negedge clk); en = 1;
    seen_rel = 0;
    for (int i = 0; i < 300 && reg_en != 3'b111; i++) begin @(negedge clk); seen_rel |= rst_rel; end
    for (int i = 0; i < 300 && reg_en != 0; i++) begin @(negedge clk); seen_rel |= rst_rel; end
    step(3); #2;
    chk(seen_rel, 0, "R10 reset never released");
    chk(reg_en, 0, "R10 automatic turn-off");

    // R4 withheld power-good
    @(negedge clk); en = 0;
    step(2);
    @(negedge clk); pg = 3'b011; hold = 1; en = 1;
    for (int i = 0; i < 300 && reg_en != 3'b111; i++) @(negedge clk);
    step(20); #2;
    chk(rst_rel, 0, "R4 waits for power-good");
    chk(seq_done, 0, "R4 done not set without power-good");
    @(negedge clk); pg = 3'b111;
    for (int i = 0; i < 50 && !rst_rel; i++) @(negedge clk);
    #2;
    chk(rst_rel, 1, "R4 active once good");

    // R7 enable low timeout clears done while active
    @(negedge clk); en = 0;
    step(20); #2;
    chk(seq_done, 0, "R7 cleared by timeout");
    chk(rst_rel, 1, "R7 still active");

    // R9 zero first delay gives fixed pulse
    @(negedge clk); hold = 0;
    for (int i = 0; i < 300 && reg_en != 0; i++) @(negedge clk);
    step(3);
    @(negedge clk); t1 = 0; hold = 1; en = 1;
    step(2); #2;
    chk(start_oe, 1, "R9 pulse begins");
    step(20); #2;
    chk(start_oe, 0, "R9 pulse ends");
    for (int i = 0; i < 300 && !rst_rel; i++) @(negedge clk);
    #2;
    chk(rst_rel, 1, "R2 start-up with zero delay");

    step(5);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule